// File: doc/BRIEF.md
# Software Breakpoint Patch Controller

This block keeps a small table of software breakpoints for a microcontroller whose program memory is addressed in 16-bit words. A breakpoint is set by swapping the instruction word at a program address for a fixed break opcode, while the original word is kept in the table. A core that fetches the break opcode traps to the debugger. The core, the decoding of the break opcode and the debugger link lie outside this block.

Commands arrive over a valid/ready handshake and carry an operation code and a program address. Insert saves the word at the address and patches in the break opcode. Remove restores the word and drops the entry. Disable-all puts back every saved word but keeps the table. Enable-all re-patches every entry. Program memory is reached through a simple port: a read request returns its word one cycle later, and a write request takes effect at the clock edge. The end of every accepted command is marked by a one-cycle `done` pulse, and a rejected command raises one of three error flags in that same cycle.

Top module: `bkpt_patcher`

## Requirements
- R1: After reset `cmd_ready` is 1, `done`, the error flags, `mem_rd` and `mem_we` are 0, and the table is empty, so a remove reports `err_absent`.
- R2: Insert (`cmd_op` 2'b00) reads the word at `cmd_pc` in the cycle after acceptance, writes 16'h9598 to the same address in the next cycle, and pulses `done` one cycle later.
- R3: Remove (`cmd_op` 2'b01) of a listed address writes its saved word back in the cycle after acceptance and deletes the entry, so a second remove of that address reports `err_absent`.
- R4: Remove of an address with no entry raises `err_absent` together with `done` in the cycle after acceptance and makes no memory access.
- R5: Enable-all (`cmd_op` 2'b10) reads each entry's address. A word that differs from 16'h9598 becomes that entry's new saved word and is replaced by 16'h9598. A word that already equals 16'h9598 is left alone and is not saved. Each entry takes two cycles.
- R6: The table holds `DEPTH` (default 8) entries. An insert of a new address when the table is full raises `err_full` with `done` in the cycle after acceptance and makes no memory access.
- R7: An insert at an address already in the table raises `err_dup` with `done` in the cycle after acceptance and makes no memory access. This check takes priority over the full check.
- R8: Disable-all (`cmd_op` 2'b11) writes each saved word back, one entry per cycle, and keeps every entry, so a later remove or enable-all still acts on them.
- R9: Enable-all and disable-all visit the entries in ascending address order, whatever order they were inserted in.
- R10: `cmd_ready` stays low from the cycle after acceptance until the cycle in which `done` is high. Memory is never read and written in the same cycle.
- R11: `done` pulses for one cycle after the last memory access of a command, or in the cycle after acceptance for a rejected command or for a walk over an empty table. At most one error flag is high at a time, and only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 00 insert, 01 remove, 10 enable-all, 11 disable-all |
| cmd_pc | input | PC_W | Word address for insert and remove |
| mem_rd | output | 1 | Program memory read request |
| mem_we | output | 1 | Program memory write request |
| mem_addr | output | PC_W | Program memory word address |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read, valid in the cycle after `mem_rd` |
| done | output | 1 | Command finished (one-cycle pulse) |
| err_full | output | 1 | Insert rejected: table full |
| err_absent | output | 1 | Remove rejected: address not listed |
| err_dup | output | 1 | Insert rejected: address already listed |

## Verification
On every cycle, the assertions check four things: an insert patch always follows a read of the same address, the table stays sorted and never overflows or deletes a missing slot, the break opcode is never saved as an original, and the error flags are one-hot and only appear with `done`. Other behaviour can only be shown by the bench's scenarios. These include the exact words that end up in program memory after each command, the restoring of a word that was changed behind the block's back between a disable and an enable, the ascending order of the walk addresses, and the cycle counts of every command kind.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] BREAK_WORD = 16'h9598;

  typedef enum logic [1:0] {
    OP_INSERT  = 2'b00,
    OP_REMOVE  = 2'b01,
    OP_ENABLE  = 2'b10,
    OP_DISABLE = 2'b11
  } bkpt_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INS_RD,
    ST_INS_WR,
    ST_RM_WR,
    ST_EN_RD,
    ST_EN_WR,
    ST_DIS_WR
  } seq_state_e;

endpackage

// File: rtl/bkpt_table.sv
module bkpt_table
  import bkpt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   q_pc,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  input  logic              ins_en,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic [WORD_W-1:0] ins_word,
  input  logic              del_en,
  input  logic [IDX_W-1:0]  del_idx,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [WORD_W-1:0] upd_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PC_W-1:0]   rd_pc,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  typedef logic [PC_W-1:0] pc_arr_t [DEPTH];

  pc_arr_t           ent_pc;
  logic [WORD_W-1:0] ent_word [DEPTH];
  logic [CNT_W-1:0]  ins_pos;

  // Number of live entries whose address lies below pc: the sorted slot for pc.
  function automatic logic [CNT_W-1:0] rank_below(input pc_arr_t pcs,
                                                  input logic [CNT_W-1:0] cnt,
                                                  input logic [PC_W-1:0] pc);
    logic [CNT_W-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++)
      if ((CNT_W'(i) < cnt) && (pcs[i] < pc)) r = r + CNT_W'(1);
    return r;
  endfunction

  assign ins_pos = rank_below(ent_pc, count, ins_pc);
  assign full    = (count == CNT_W'(DEPTH));
  assign rd_pc   = ent_pc[rd_idx];
  assign rd_word = ent_word[rd_idx];

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count) && (ent_pc[i] == q_pc)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (ins_en) count <= count + CNT_W'(1);
    else if (del_en) count <= count - CNT_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(g);
    localparam logic [IDX_W-1:0] SLOT_I = IDX_W'(g);
    logic [PC_W-1:0]   below_pc, above_pc;
    logic [WORD_W-1:0] below_word, above_word;

    if (g == 0) begin : g_first
      assign below_pc   = '0;
      assign below_word = '0;
    end else begin : g_inner
      assign below_pc   = ent_pc[g-1];
      assign below_word = ent_word[g-1];
    end
    if (g == DEPTH - 1) begin : g_last
      assign above_pc   = '0;
      assign above_word = '0;
    end else begin : g_mid
      assign above_pc   = ent_pc[g+1];
      assign above_word = ent_word[g+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_pc[g]   <= '0;
        ent_word[g] <= '0;
      end else if (ins_en) begin
        if (SLOT_C > ins_pos) begin
          ent_pc[g]   <= below_pc;
          ent_word[g] <= below_word;
        end else if (SLOT_C == ins_pos) begin
          ent_pc[g]   <= ins_pc;
          ent_word[g] <= ins_word;
        end
      end else if (del_en) begin
        if (SLOT_I >= del_idx) begin
          ent_pc[g]   <= above_pc;
          ent_word[g] <= above_word;
        end
      end else if (upd_en && (upd_idx == SLOT_I)) begin
        ent_word[g] <= upd_word;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full); // R6
  AST_DELETE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    del_en |-> (CNT_W'(del_idx) < count)); // R3
  AST_SINGLE_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_en, del_en, upd_en})); // R10

  for (genvar s = 0; s + 1 < DEPTH; s++) begin : g_order_chk
    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(s + 1) < count) |-> (ent_pc[s] < ent_pc[s+1])); // R9
  end

endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [PC_W-1:0]   cmd_pc,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic [CNT_W-1:0]  count,
  input  logic              full,
  output logic              ins_en,
  output logic [PC_W-1:0]   ins_pc,
  output logic [WORD_W-1:0] ins_word,
  output logic              del_en,
  output logic [IDX_W-1:0]  del_idx,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [WORD_W-1:0] upd_word,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [PC_W-1:0]   rd_pc,
  input  logic [WORD_W-1:0] rd_word,
  output logic              done,
  output logic              err_full,
  output logic              err_absent,
  output logic              err_dup
);

  seq_state_e      state, state_nx;
  logic [PC_W-1:0] pc_q;
  logic [IDX_W-1:0] idx_q;
  bkpt_op_e        op;

  function automatic logic is_last_slot(input logic [IDX_W-1:0] idx,
                                        input logic [CNT_W-1:0] cnt);
    return (CNT_W'(idx) + CNT_W'(1)) == cnt;
  endfunction

  // Named events for the assertions and the completion logic.
  logic accept, rej_dup, rej_full, rej_absent, empty_walk, walk_last, finish, start_ok;

  assign op         = bkpt_op_e'(cmd_op);
  assign cmd_ready  = (state == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign rej_dup    = accept && (op == OP_INSERT) && hit;
  assign rej_full   = accept && (op == OP_INSERT) && !hit && full;
  assign rej_absent = accept && (op == OP_REMOVE) && !hit;
  assign empty_walk = accept && ((op == OP_ENABLE) || (op == OP_DISABLE)) && (count == '0);
  assign start_ok   = accept && !rej_dup && !rej_full && !rej_absent && !empty_walk;
  assign walk_last  = is_last_slot(idx_q, count);
  assign finish     = rej_dup || rej_full || rej_absent || empty_walk ||
                      (state == ST_INS_WR) || (state == ST_RM_WR) ||
                      (((state == ST_EN_WR) || (state == ST_DIS_WR)) && walk_last);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start_ok) begin
        unique case (op)
          OP_INSERT:  state_nx = ST_INS_RD;
          OP_REMOVE:  state_nx = ST_RM_WR;
          OP_ENABLE:  state_nx = ST_EN_RD;
          OP_DISABLE: state_nx = ST_DIS_WR;
          default:    state_nx = ST_IDLE;
        endcase
      end
      ST_INS_RD: state_nx = ST_INS_WR;
      ST_INS_WR: state_nx = ST_IDLE;
      ST_RM_WR:  state_nx = ST_IDLE;
      ST_EN_RD:  state_nx = ST_EN_WR;
      ST_EN_WR:  state_nx = walk_last ? ST_IDLE : ST_EN_RD;
      ST_DIS_WR: state_nx = walk_last ? ST_IDLE : ST_DIS_WR;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pc_q       <= '0;
      idx_q      <= '0;
      done       <= 1'b0;
      err_full   <= 1'b0;
      err_absent <= 1'b0;
      err_dup    <= 1'b0;
    end else begin
      state      <= state_nx;
      done       <= finish;
      err_full   <= rej_full;
      err_absent <= rej_absent;
      err_dup    <= rej_dup;
      if (start_ok) begin
        pc_q  <= cmd_pc;
        idx_q <= (op == OP_REMOVE) ? hit_idx : '0;
      end else if (((state == ST_EN_WR) || (state == ST_DIS_WR)) && !walk_last) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = rd_pc;
    mem_wdata = BREAK_WORD;
    ins_en    = 1'b0;
    ins_pc    = pc_q;
    ins_word  = mem_rdata;
    del_en    = 1'b0;
    del_idx   = idx_q;
    upd_en    = 1'b0;
    upd_idx   = idx_q;
    upd_word  = mem_rdata;
    rd_idx    = idx_q;
    unique case (state)
      ST_INS_RD: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q;
      end
      ST_INS_WR: begin
        mem_we   = 1'b1;
        mem_addr = pc_q;
        ins_en   = 1'b1;
      end
      ST_RM_WR: begin
        mem_we    = 1'b1;
        mem_wdata = rd_word;
        del_en    = 1'b1;
      end
      ST_EN_RD: mem_rd = 1'b1;
      ST_EN_WR: if (mem_rdata != BREAK_WORD) begin
        mem_we = 1'b1;
        upd_en = 1'b1;
      end
      ST_DIS_WR: begin
        mem_we    = 1'b1;
        mem_wdata = rd_word;
      end
      default: ;
    endcase
  end

  AST_READ_BEFORE_PATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> ($past(mem_rd) && ($past(mem_addr) == mem_addr) && (mem_wdata == BREAK_WORD))); // R2
  AST_NO_BREAK_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (upd_word != BREAK_WORD)); // R5
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we)); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_we) |-> !cmd_ready); // R10
  AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_full, err_absent, err_dup})); // R11
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_full || err_absent || err_dup) |-> done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R11

endmodule

// File: rtl/bkpt_patcher.sv
module bkpt_patcher
  import bkpt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [PC_W-1:0]   cmd_pc,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              done,
  output logic              err_full,
  output logic              err_absent,
  output logic              err_dup
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              hit, full, ins_en, del_en, upd_en;
  logic [IDX_W-1:0]  hit_idx, del_idx, upd_idx, rd_idx;
  logic [CNT_W-1:0]  count;
  logic [PC_W-1:0]   ins_pc, rd_pc;
  logic [WORD_W-1:0] ins_word, upd_word, rd_word;

  bkpt_table #(.DEPTH(DEPTH), .PC_W(PC_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_pc     (cmd_pc),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .ins_en   (ins_en),
    .ins_pc   (ins_pc),
    .ins_word (ins_word),
    .del_en   (del_en),
    .del_idx  (del_idx),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_word (upd_word),
    .rd_idx   (rd_idx),
    .rd_pc    (rd_pc),
    .rd_word  (rd_word),
    .count    (count),
    .full     (full)
  );

  bkpt_seq #(.DEPTH(DEPTH), .PC_W(PC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_pc     (cmd_pc),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .count      (count),
    .full       (full),
    .ins_en     (ins_en),
    .ins_pc     (ins_pc),
    .ins_word   (ins_word),
    .del_en     (del_en),
    .del_idx    (del_idx),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_word   (upd_word),
    .rd_idx     (rd_idx),
    .rd_pc      (rd_pc),
    .rd_word    (rd_word),
    .done       (done),
    .err_full   (err_full),
    .err_absent (err_absent),
    .err_dup    (err_dup)
  );

endmodule

// File: tb/test_bkpt_patcher.sv
module test_bkpt_patcher;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BRK = 16'h9598;
  localparam logic [1:0] C_INS = 2'b00, C_REM = 2'b01, C_ENA = 2'b10, C_DIS = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [15:0] cmd_pc = '0;
  logic cmd_ready, mem_rd, mem_we, done, err_full, err_absent, err_dup;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_patcher i_bkpt_patcher (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err_full(err_full), .err_absent(err_absent), .err_dup(err_dup)
  );

  // Program memory model: one-cycle read latency, plus a bench-side poke port.
  logic [15:0] pmem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_a  = '0;
  logic [15:0] poke_d  = '0;
  logic        log_clr = 1'b0;
  int          acc_cnt = 0;
  int          wn = 0;
  logic [15:0] wlog [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) pmem[k] <= 16'h1000 + 16'(k);
    end else begin
      if (poke_en) pmem[poke_a] <= poke_d;
      if (mem_we) pmem[mem_addr[7:0]] <= mem_wdata;
    end
    if (mem_rd) mem_rdata <= pmem[mem_addr[7:0]];
    if (mem_rd || mem_we) acc_cnt <= acc_cnt + 1;
    if (log_clr) wn <= 0;
    else if (mem_we && wn < 16) begin
      wlog[wn] <= mem_addr;
      wn <= wn + 1;
    end
  end

  function automatic logic [15:0] orig(input logic [15:0] a);
    return 16'h1000 + a;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issue one command; return latency to done, error flags, memory accesses,
  // and whether ready was seen high while busy.
  task automatic run_cmd(input logic [1:0] op, input logic [15:0] pc, output int lat,
                         output logic [2:0] errs, output int acc, output bit rdy_busy);
    int a0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc;
    while (!cmd_ready) @(negedge clk);
    a0 = acc_cnt;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    rdy_busy = 1'b0;
    while (!done && lat < 200) begin
      if (cmd_ready) rdy_busy = 1'b1;
      @(negedge clk);
      lat++;
    end
    errs = {err_full, err_absent, err_dup};
    acc = acc_cnt - a0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // {op, pc, err{full,absent,dup}, word at pc after, latency, accesses}
  localparam int NV = 11;
  localparam logic [48:0] VEC [NV] = '{
    {C_INS, 16'h0020, 3'b000, BRK,      8'd3, 4'd2},  // R2
    {C_INS, 16'h0010, 3'b000, BRK,      8'd3, 4'd2},  // R2
    {C_INS, 16'h0020, 3'b001, BRK,      8'd1, 4'd0},  // R7
    {C_REM, 16'h0030, 3'b010, 16'h1030, 8'd1, 4'd0},  // R4
    {C_REM, 16'h0010, 3'b000, 16'h1010, 8'd2, 4'd1},  // R3
    {C_REM, 16'h0010, 3'b010, 16'h1010, 8'd1, 4'd0},  // R3 entry gone
    {C_DIS, 16'h0020, 3'b000, 16'h1020, 8'd2, 4'd1},  // R8
    {C_ENA, 16'h0020, 3'b000, BRK,      8'd3, 4'd2},  // R5
    {C_ENA, 16'h0020, 3'b000, BRK,      8'd3, 4'd1},  // R5 already patched
    {C_REM, 16'h0020, 3'b000, 16'h1020, 8'd2, 4'd1},  // R3
    {C_DIS, 16'h0000, 3'b000, 16'h1000, 8'd1, 4'd0}   // R11 empty walk
  };

  function automatic string tag_of(input logic [1:0] op, input logic [2:0] e);
    if (e == 3'b001) return "R7";
    if (e == 3'b010) return "R4";
    if (e == 3'b100) return "R6";
    case (op)
      C_INS:   return "R2";
      C_REM:   return "R3";
      C_ENA:   return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int lat, acc;
    logic [2:0] errs;
    bit rb;
    logic [15:0] fpcs [8];
    fpcs = '{16'h58, 16'h40, 16'h70, 16'h48, 16'h60, 16'h50, 16'h78, 16'h68};

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 1);
    chk({mem_rd, mem_we, done, err_full, err_absent, err_dup} == 6'b0, "R1 idle outputs",
        32'({mem_rd, mem_we, done, err_full, err_absent, err_dup}), 0);
    run_cmd(C_REM, 16'h0005, lat, errs, acc, rb);
    chk(errs == 3'b010 && acc == 0, "R1 empty table remove", 32'({errs, 4'(acc)}), 32'({3'b010, 4'd0}));

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [15:0] pc, wexp;
      logic [2:0] eexp;
      int lexp, aexp;
      op = VEC[i][48:47]; pc = VEC[i][46:31]; eexp = VEC[i][30:28];
      wexp = VEC[i][27:12]; lexp = int'(VEC[i][11:4]); aexp = int'(VEC[i][3:0]);
      run_cmd(op, pc, lat, errs, acc, rb);
      chk(errs == eexp, $sformatf("%s vec%0d errors", tag_of(op, eexp), i), 32'(errs), 32'(eexp));
      chk(pmem[pc[7:0]] == wexp, $sformatf("%s vec%0d memory word", tag_of(op, eexp), i), 32'(pmem[pc[7:0]]), 32'(wexp));
      chk(lat == lexp, $sformatf("R11 vec%0d done latency", i), 32'(lat), 32'(lexp));
      chk(acc == aexp, $sformatf("%s vec%0d access count", tag_of(op, eexp), i), 32'(acc), 32'(aexp));
      chk(!rb, $sformatf("R10 vec%0d ready while busy", i), 32'(rb), 0);
    end

    // Fill the table in shuffled order: R6
    for (int i = 0; i < 8; i++) begin
      run_cmd(C_INS, fpcs[i], lat, errs, acc, rb);
      chk(errs == 3'b000 && pmem[fpcs[i][7:0]] == BRK, "R6 fill insert",
          32'({errs, pmem[fpcs[i][7:0]]}), 32'({3'b000, BRK}));
    end
    run_cmd(C_INS, 16'h0080, lat, errs, acc, rb);
    chk(errs == 3'b100, "R6 full error", 32'(errs), 32'(3'b100));
    chk(acc == 0 && pmem[8'h80] == orig(16'h80), "R6 full no access",
        32'({4'(acc), pmem[8'h80]}), 32'({4'd0, orig(16'h80)}));
    chk(lat == 1, "R11 full done latency", 32'(lat), 1);
    run_cmd(C_INS, 16'h0040, lat, errs, acc, rb);
    chk(errs == 3'b001 && acc == 0, "R7 dup priority over full", 32'({errs, 4'(acc)}), 32'({3'b001, 4'd0}));

    // Disable-all: ascending walk, all restored: R8, R9
    @(negedge clk); log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
    run_cmd(C_DIS, 16'h0, lat, errs, acc, rb);
    chk(lat == 9 && acc == 8, "R8 disable walk length", 32'({8'(lat), 8'(acc)}), 32'({8'd9, 8'd8}));
    chk(wn == 8, "R9 walk write count", 32'(wn), 8);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] ea;
      ea = 16'h40 + 16'(8 * i);
      chk(wlog[i] == ea, $sformatf("R9 walk order slot %0d", i), 32'(wlog[i]), 32'(ea));
      chk(pmem[ea[7:0]] == orig(ea), "R8 restored word", 32'(pmem[ea[7:0]]), 32'(orig(ea)));
    end
    chk(!rb, "R10 busy during disable walk", 32'(rb), 0);

    // Word changed behind the block, then enable re-saves it: R5
    poke(8'h50, 16'hABCD);
    run_cmd(C_ENA, 16'h0, lat, errs, acc, rb);
    chk(lat == 17 && acc == 16, "R5 enable walk length", 32'({8'(lat), 8'(acc)}), 32'({8'd17, 8'd16}));
    for (int i = 0; i < 8; i++)
      chk(pmem[8'h40 + 8'(8 * i)] == BRK, "R5 re-patched", 32'(pmem[8'h40 + 8'(8 * i)]), 32'(BRK));
    run_cmd(C_ENA, 16'h0, lat, errs, acc, rb);
    chk(acc == 8, "R5 enable of patched words only reads", 32'(acc), 8);
    run_cmd(C_DIS, 16'h0, lat, errs, acc, rb);
    chk(pmem[8'h50] == 16'hABCD, "R5 new original saved", 32'(pmem[8'h50]), 32'hABCD);
    chk(pmem[8'h48] == orig(16'h48), "R8 other word restored", 32'(pmem[8'h48]), 32'(orig(16'h48)));

    // Entries survive disable: remove still acts: R8, R3
    poke(8'h60, 16'h7777);
    run_cmd(C_REM, 16'h0060, lat, errs, acc, rb);
    chk(errs == 3'b000 && lat == 2, "R8 entry kept after disable", 32'({errs, 8'(lat)}), 32'({3'b000, 8'd2}));
    chk(pmem[8'h60] == orig(16'h60), "R3 saved word written back", 32'(pmem[8'h60]), 32'(orig(16'h60)));
    run_cmd(C_REM, 16'h0060, lat, errs, acc, rb);
    chk(errs == 3'b010, "R3 second remove absent", 32'(errs), 32'(3'b010));

    @(negedge clk);
    chk(done == 1'b0, "R11 done is a single pulse", 32'(done), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule